// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a watchdog timer controlled through one 32-bit control/status word. Software writes the word to choose a timeout, to turn the timer on, and to restart it. The timeout is the product of a clock prescaler, picked by a two-bit divider field, and an interval length, picked by a two-bit interval field. If software does not restart the timer before the interval runs out, the block sets a sticky interrupt flag. That flag can drive an interrupt line, which serves as an early warning. After a further fixed number of prescaled ticks, and only when reset generation is enabled, the block drives a system reset pulse and records that it did so in a sticky reset flag.

The reset flag is cleared only by a power-on reset, so software can read it after the watchdog has rebooted the system and learn why the reboot happened. Every other field returns to zero on an ordinary reset. Writing an all-zero word halts the timer. Software restarts the timer with a read-modify-write that sets the restart bit and keeps the other fields. The restart bit itself always reads back as zero.

Top module: `wdog_top`

## Requirements
- R1: After either reset the outputs `irq` and `sys_rst` are 0. After a power-on reset, `rd_data` reads as 0.
- R2: The field layout is as follows. Bits [11:10] are the divider select, bit 7 is enable, bit 6 is interrupt enable, bits [5:4] are the interval select, bit 3 is the interrupt flag, bit 2 is the reset flag, bit 1 is reset enable and bit 0 is restart. All other bits read as 0, and bit 0 always reads as 0. Writing all ones with both flags clear reads back 0x0000_0CF2.
- R3: Suppose a write sets enable and restart with divider select d and interval select i. The interrupt flag is still 0 after clock edge N-1, counted from that write edge, and is 1 after edge N. Here N = PRE_BASE·2^s(d)·IVL_BASE·4^i, and s(00)=0, s(01)=3, s(10)=6, s(11)=11.
- R4: The interrupt flag is set on expiry whatever the interrupt enable holds. `irq` equals the interrupt flag ANDed with interrupt enable, so setting the enable later exposes a flag that is already pending.
- R5: A write with bit 0 set clears both the prescaler and interval counts and also cancels a pending post-expiry delay. Counting then starts again from the write edge.
- R6: A restart write that lands on the very clock edge of expiry wins. The flag stays 0, and the next expiry comes N edges later.
- R7: With reset enable set, `sys_rst` rises after the edge that is RST_DELAY prescaled ticks (RST_DELAY·D cycles, where D = PRE_BASE·2^s(d)) past expiry. On that same edge the reset flag sets. `sys_rst` then stays high for exactly RST_PULSE cycles. With reset enable clear, neither `sys_rst` nor the reset flag changes.
- R8: A restart plus enable plus reset-enable write, with interrupt enable clear, still produces the reset pulse, while `irq` stays 0.
- R9: Each flag is cleared by writing 1 to its bit, and writing 0 leaves it unchanged. If a clearing write and the setting event fall on the same edge, the flag ends up set.
- R10: Writing an all-zero word stops all counting. No flag sets however long the block then waits. A later write of enable without restart times a full interval again from that write.
- R11: The reset flag survives `rst_n` and is cleared only by `por_n`. `rst_n` clears every other field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, async active low. Clears everything, including the reset flag |
| rst_n | input | 1 | System reset, async active low. Clears everything except the reset flag |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Current control/status word |
| irq | output | 1 | Early-warning interrupt |
| sys_rst | output | 1 | System reset pulse, active high |

## Verification
Two kinds of events can share a clock edge. The first is a software write, either a restart or a flag clear. The second is the expiry the timer raises on its own. The bench computes the exact expiry edge from the divider and interval settings, then times a restart write to land on that edge. It expects the restart to win, leaving the flag clear and the next expiry a full interval later. It also times a flag-clearing write to land on that edge, where it expects the set to win. Random configurations, drawn from a fixed seed, check the cycle at which the flag and the reset pulse appear for each setting against formulas held in the bench.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned WORD_W = 32;

  // bit positions inside the control/status word
  localparam int unsigned KICK_B  = 0;
  localparam int unsigned RSTEN_B = 1;
  localparam int unsigned RFLAG_B = 2;
  localparam int unsigned IFLAG_B = 3;
  localparam int unsigned ISEL_LO = 4;
  localparam int unsigned IRQEN_B = 6;
  localparam int unsigned RUN_B   = 7;
  localparam int unsigned DSEL_LO = 10;

  typedef enum logic [1:0] {
    PH_COUNT = 2'd0,
    PH_DELAY = 2'd1,
    PH_DONE  = 2'd2
  } wd_phase_e;

  typedef struct packed {
    logic [1:0] dsel;
    logic       run;
    logic       irq_en;
    logic [1:0] isel;
    logic       rst_en;
  } wd_cfg_t;

  // log2 of the prescale multiplier for each divider select code
  function automatic logic [3:0] dsel_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd0;
      2'd1:    return 4'd3;
      2'd2:    return 4'd6;
      default: return 4'd11;
    endcase
  endfunction

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int unsigned PRE_BASE = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [1:0] dsel_i,
  output logic       tick_o
);

  localparam int unsigned MAX_DIV = PRE_BASE << 11;
  localparam int unsigned CW      = $clog2(MAX_DIV);

  logic [CW-1:0] pcnt_q, pcnt_d, lim;
  logic [3:0]    sh;
  logic          hit, pcnt_en;

  always_comb begin
    sh      = dsel_shift(dsel_i);
    lim     = (CW'(PRE_BASE) << sh) - CW'(1);
    hit     = (pcnt_q >= lim);
    tick_o  = run_i & hit;
    pcnt_en = clr_i | run_i;
    if (clr_i) begin
      pcnt_d = '0;
    end else if (hit) begin
      pcnt_d = '0;
    end else begin
      pcnt_d = pcnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
    end else if (pcnt_en) begin
      pcnt_q <= pcnt_d;
    end
  end

  // every tick restarts the division window
  assert_tick_wraps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (pcnt_q == '0));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned IVL_BASE  = 16,
  parameter int unsigned RST_DELAY = 1024,
  parameter int unsigned RST_PULSE = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic [1:0] isel_i,
  input  logic       rst_en_i,
  output logic       expire_o,
  output logic       fire_o,
  output logic       sys_rst_o
);

  localparam int unsigned IW = $clog2(IVL_BASE << 6);
  localparam int unsigned DW = $clog2(RST_DELAY + 1);
  localparam int unsigned PW = $clog2(RST_PULSE + 1);

  wd_phase_e     phase_q, phase_d;
  logic [IW-1:0] icnt_q, icnt_d, ilim;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic [PW-1:0] pul_q, pul_d;
  logic          delay_done, cnt_en;

  // interval and post-expiry phase
  always_comb begin
    ilim       = (IW'(IVL_BASE) << {isel_i, 1'b0}) - IW'(1);
    phase_d    = phase_q;
    icnt_d     = icnt_q;
    dcnt_d     = dcnt_q;
    expire_o   = 1'b0;
    delay_done = 1'b0;
    cnt_en     = clr_i | tick_i;
    if (clr_i) begin
      phase_d = PH_COUNT;
      icnt_d  = '0;
      dcnt_d  = '0;
    end else if (tick_i) begin
      case (phase_q)
        PH_COUNT: begin
          if (icnt_q >= ilim) begin
            expire_o = 1'b1;
            icnt_d   = '0;
            dcnt_d   = '0;
            phase_d  = PH_DELAY;
          end else begin
            icnt_d = icnt_q + IW'(1);
          end
        end
        PH_DELAY: begin
          if (dcnt_q >= DW'(RST_DELAY - 1)) begin
            delay_done = 1'b1;
            phase_d    = PH_DONE;
          end else begin
            dcnt_d = dcnt_q + DW'(1);
          end
        end
        default: phase_d = phase_q;
      endcase
    end
  end

  assign fire_o = delay_done & rst_en_i;

  // reset pulse stretcher, not cut short by a restart
  always_comb begin
    if (fire_o) begin
      pul_d = PW'(RST_PULSE);
    end else if (pul_q != '0) begin
      pul_d = pul_q - PW'(1);
    end else begin
      pul_d = pul_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_COUNT;
      icnt_q  <= '0;
      dcnt_q  <= '0;
    end else if (cnt_en) begin
      phase_q <= phase_d;
      icnt_q  <= icnt_d;
      dcnt_q  <= dcnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pul_q <= '0;
    end else begin
      pul_q <= pul_d;
    end
  end

  assign sys_rst_o = (pul_q != '0);

  assert_restart_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (icnt_q == '0 && dcnt_q == '0 && phase_q == PH_COUNT));

  assert_expire_enters_delay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (phase_q == PH_DELAY));

  assert_fire_starts_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> sys_rst_o);

  assert_fire_from_delay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (phase_q == PH_DELAY));

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              expire_i,
  input  logic              fire_i,
  output wd_cfg_t           cfg_o,
  output logic              kick_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              irq_o
);

  wd_cfg_t cfg_q, cfg_d;
  logic    iflag_q, iflag_d;
  logic    rflag_q, rflag_d;
  logic    unused_wr_bits;

  assign unused_wr_bits = ^{wr_data_i[WORD_W-1:DSEL_LO+2], wr_data_i[RUN_B+2:RUN_B+1]};

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en_i) begin
      cfg_d.dsel   = wr_data_i[DSEL_LO +: 2];
      cfg_d.run    = wr_data_i[RUN_B];
      cfg_d.irq_en = wr_data_i[IRQEN_B];
      cfg_d.isel   = wr_data_i[ISEL_LO +: 2];
      cfg_d.rst_en = wr_data_i[RSTEN_B];
    end
    kick_o = wr_en_i & wr_data_i[KICK_B];
    // setting event wins over a write-one-to-clear on the same edge
    if (expire_i) begin
      iflag_d = 1'b1;
    end else if (wr_en_i && wr_data_i[IFLAG_B]) begin
      iflag_d = 1'b0;
    end else begin
      iflag_d = iflag_q;
    end
    if (fire_i) begin
      rflag_d = 1'b1;
    end else if (wr_en_i && wr_data_i[RFLAG_B]) begin
      rflag_d = 1'b0;
    end else begin
      rflag_d = rflag_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      iflag_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        cfg_q <= cfg_d;
      end
      iflag_q <= iflag_d;
    end
  end

  // survives the system reset, cleared only at power-on
  always_ff @(posedge clk_i or negedge flag_rst_ni) begin
    if (!flag_rst_ni) begin
      rflag_q <= 1'b0;
    end else begin
      rflag_q <= rflag_d;
    end
  end

  always_comb begin
    rd_data_o                = '0;
    rd_data_o[DSEL_LO +: 2]  = cfg_q.dsel;
    rd_data_o[RUN_B]         = cfg_q.run;
    rd_data_o[IRQEN_B]       = cfg_q.irq_en;
    rd_data_o[ISEL_LO +: 2]  = cfg_q.isel;
    rd_data_o[IFLAG_B]       = iflag_q;
    rd_data_o[RFLAG_B]       = rflag_q;
    rd_data_o[RSTEN_B]       = cfg_q.rst_en;
  end

  assign cfg_o = cfg_q;
  assign irq_o = iflag_q & cfg_q.irq_en;

  assert_iflag_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iflag_q) |-> $past(expire_i));

  assert_rflag_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rflag_q) |-> $past(fire_i));

  assert_w1c_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[IFLAG_B] && !expire_i) |=> !iflag_q);

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> iflag_q);

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned PRE_BASE  = 2,
  parameter int unsigned IVL_BASE  = 16,
  parameter int unsigned RST_DELAY = 1024,
  parameter int unsigned RST_PULSE = 16
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        sys_rst
);

  logic    core_rst_n, flag_rst_n;
  logic    kick, clr, tick, expire, fire;
  wd_cfg_t cfg;

  wdog_rst_sync #(.STAGES(2)) u_core_sync (
    .clk_i   (clk),
    .arst_ni (rst_n & por_n),
    .rst_no  (core_rst_n)
  );

  wdog_rst_sync #(.STAGES(2)) u_flag_sync (
    .clk_i   (clk),
    .arst_ni (por_n),
    .rst_no  (flag_rst_n)
  );

  wdog_regs u_regs (
    .clk_i       (clk),
    .rst_ni      (core_rst_n),
    .flag_rst_ni (flag_rst_n),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .expire_i    (expire),
    .fire_i      (fire),
    .cfg_o       (cfg),
    .kick_o      (kick),
    .rd_data_o   (rd_data),
    .irq_o       (irq)
  );

  assign clr = kick | ~cfg.run;

  wdog_prescaler #(.PRE_BASE(PRE_BASE)) u_presc (
    .clk_i  (clk),
    .rst_ni (core_rst_n),
    .run_i  (cfg.run),
    .clr_i  (clr),
    .dsel_i (cfg.dsel),
    .tick_o (tick)
  );

  wdog_timer #(
    .IVL_BASE  (IVL_BASE),
    .RST_DELAY (RST_DELAY),
    .RST_PULSE (RST_PULSE)
  ) u_timer (
    .clk_i     (clk),
    .rst_ni    (core_rst_n),
    .clr_i     (clr),
    .tick_i    (tick),
    .isel_i    (cfg.isel),
    .rst_en_i  (cfg.rst_en),
    .expire_o  (expire),
    .fire_o    (fire),
    .sys_rst_o (sys_rst)
  );

  assert_stopped_no_expiry_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    !cfg.run |-> !expire);

endmodule

// File: tb/wdog_top_bench.sv
module wdog_top_bench;

  localparam int unsigned PB = 1;
  localparam int unsigned IB = 1;
  localparam int unsigned RD = 3;
  localparam int unsigned RP = 5;

  logic        clk;
  logic        por_n, rst_n, wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq, sys_rst;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  wdog_top #(.PRE_BASE(PB), .IVL_BASE(IB), .RST_DELAY(RD), .RST_PULSE(RP)) u_wdog_top (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .sys_rst(sys_rst)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int unsigned exp_div(input int unsigned d);
    case (d)
      0: return PB;
      1: return PB * 8;
      2: return PB * 64;
      default: return PB * 2048;
    endcase
  endfunction

  function automatic int unsigned exp_len(input int unsigned i);
    return IB << (2 * i);
  endfunction

  function automatic logic [31:0] cfg_word(input int unsigned d, input int unsigned i,
                                           input bit en, input bit ie, input bit re, input bit k);
    return (32'(d) << 10) | (32'(en) << 7) | (32'(ie) << 6) | (32'(i) << 4) | (32'(re) << 1) | 32'(k);
  endfunction

  task automatic report;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cycles(input int unsigned n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // called at a negedge; leaves at the negedge after the write edge
  task automatic do_write(input logic [31:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic power_on;
    por_n = 1'b0;
    rst_n = 1'b0;
    wait_cycles(2);
    por_n = 1'b1;
    rst_n = 1'b1;
    wait_cycles(4);
  endtask

  // R3/R4/R7: full timing of flag and reset pulse for one setting
  task automatic run_cfg(input int unsigned d, input int unsigned i, input bit ie, input bit re);
    int unsigned dv = exp_div(d);
    int unsigned n  = dv * exp_len(i);
    do_write(cfg_word(d, i, 1, ie, re, 1));
    wait_cycles(n - 1);
    chk("R3 flag before expiry", 32'(rd_data[3]), 0);
    wait_cycles(1);
    chk("R3 flag at expiry", 32'(rd_data[3]), 1);
    chk("R4 irq gated by enable", 32'(irq), 32'(ie));
    wait_cycles(RD * dv - 1);
    chk("R7 no reset before delay", 32'(sys_rst), 0);
    wait_cycles(1);
    chk("R7 reset after delay", 32'(sys_rst), 32'(re));
    chk("R7 reset flag", 32'(rd_data[2]), 32'(re));
    if (re) begin
      wait_cycles(RP - 1);
      chk("R7 pulse still high", 32'(sys_rst), 1);
      wait_cycles(1);
      chk("R7 pulse ends", 32'(sys_rst), 0);
    end else begin
      wait_cycles(RP + 2);
      chk("R7 no reset when disabled", 32'(sys_rst), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=finish");
    report();
  end

  initial begin
    wr_en   = 1'b0;
    wr_data = '0;
    @(negedge clk);
    power_on();

    // R1 reset state
    chk("R1 rd after power-on", rd_data, 32'h0);
    chk("R1 irq after power-on", 32'(irq), 0);
    chk("R1 sys_rst after power-on", 32'(sys_rst), 0);

    // R2 field layout
    do_write(32'hFFFF_FFFF);
    chk("R2 readback all ones", rd_data, 32'h0000_0CF2);
    do_write(32'h0);
    chk("R10 all-zero write stops", rd_data, 32'h0);

    // R3 directed on the largest divider
    power_on();
    run_cfg(3, 0, 1, 1);

    // R3/R4/R7 random configurations
    void'($urandom(32'h5EED));
    for (int k = 0; k < 12; k++) begin
      int unsigned d  = $urandom % 3;
      int unsigned i  = $urandom % 4;
      bit          ie = 1'($urandom % 2);
      bit          re = 1'($urandom % 2);
      power_on();
      run_cfg(d, i, ie, re);
    end

    // R8 forced reboot, interrupt enable clear
    power_on();
    do_write(cfg_word(1, 0, 1, 0, 1, 1));
    wait_cycles(8);
    chk("R8 flag set with irq off", 32'(rd_data[3]), 1);
    chk("R8 irq stays low", 32'(irq), 0);
    wait_cycles(RD * 8);
    chk("R8 reset pulse", 32'(sys_rst), 1);
    // R4 enabling interrupt exposes pending flag
    do_write(cfg_word(1, 0, 1, 1, 1, 0));
    chk("R4 pending flag reaches irq", 32'(irq), 1);

    // R11 reset flag retained over rst_n
    wait_cycles(RP + 2);
    rst_n = 1'b0;
    wait_cycles(2);
    rst_n = 1'b1;
    wait_cycles(4);
    chk("R11 only reset flag kept", rd_data, 32'h4);
    power_on();
    chk("R11 power-on clears reset flag", rd_data, 32'h0);

    // R9 W1C behaviour on both flags
    run_cfg(0, 0, 1, 1);
    do_write(cfg_word(0, 0, 1, 1, 1, 0));
    chk("R9 write zero keeps flags", rd_data & 32'hC, 32'hC);
    do_write(cfg_word(0, 0, 1, 1, 1, 0) | 32'h8);
    chk("R9 clear interrupt flag", rd_data & 32'hC, 32'h4);
    do_write(cfg_word(0, 0, 1, 1, 1, 0) | 32'h4);
    chk("R9 clear reset flag", rd_data & 32'hC, 32'h0);

    // R9 clear and expiry on the same edge: set wins (N = 4)
    power_on();
    do_write(cfg_word(0, 1, 1, 1, 0, 1));
    wait_cycles(3);
    do_write(cfg_word(0, 1, 1, 1, 0, 0) | 32'h8);
    chk("R9 set wins over clear", 32'(rd_data[3]), 1);

    // R6 restart on the expiry edge wins (N = 4)
    power_on();
    do_write(cfg_word(0, 1, 1, 1, 0, 1));
    wait_cycles(3);
    do_write(rd_data | 32'h1);
    chk("R6 restart beats expiry", 32'(rd_data[3]), 0);
    wait_cycles(3);
    chk("R6 no flag before new expiry", 32'(rd_data[3]), 0);
    wait_cycles(1);
    chk("R6 flag at new expiry", 32'(rd_data[3]), 1);

    // R5 restart during the post-expiry delay (d=1, i=0: N=8, delay=24)
    power_on();
    do_write(cfg_word(1, 0, 1, 0, 1, 1));
    wait_cycles(19);
    do_write(rd_data | 32'h1);
    chk("R5 restart bit reads zero", 32'(rd_data[0]), 0);
    wait_cycles(12);
    chk("R5 cancelled reset", 32'(sys_rst), 0);
    wait_cycles(19);
    chk("R5 no reset before full re-count", 32'(sys_rst), 0);
    wait_cycles(1);
    chk("R5 reset after full re-count", 32'(sys_rst), 1);

    // R10 stop then resume without restart (d=0, i=2: N=16)
    power_on();
    do_write(cfg_word(0, 2, 1, 1, 1, 1));
    wait_cycles(5);
    do_write(32'h0);
    wait_cycles(100);
    chk("R10 stopped no flag", rd_data, 32'h0);
    chk("R10 stopped no irq", 32'(irq), 0);
    do_write(cfg_word(0, 2, 1, 1, 0, 0));
    wait_cycles(15);
    chk("R10 resume before expiry", 32'(rd_data[3]), 0);
    wait_cycles(1);
    chk("R10 resume expiry", 32'(rd_data[3]), 1);

    report();
  end

endmodule